// File: doc/BRIEF.md
# Serial Port Bit-Rate Enable Generator

This block produces the timing enables for a four-mode serial port of the classic 8-bit controller type. All outputs are one-cycle pulses in the system clock domain. They are not derived clocks. In the synchronous shift mode the block issues one shift enable for each bit. In the three asynchronous modes it issues an enable at sixteen times the bit rate. The receiver and transmitter divide that enable by sixteen and use it to oversample the line.

The mode inputs pick one of three sources:
- a fixed division of the system clock;
- the overflow pulse of an external timer;
- an internal two-stage chain that divides by 2 and then by 39.

A rate-double input removes a final divide-by-two stage wherever the rate can vary. Any change of the mode, the rate-double input or the source-select input clears every internal counter. The new rate therefore starts cleanly, one full period after the change, with no short first interval.

Top module: `serial_rate_gen`

## Requirements
- R1: With mode code `sm_mode`=2'b00 (shift mode), `shift_en` pulses once every 12 cycles and `os16_en` stays low, whatever the values of `dbl_rate` and `chain_sel`.
- R2: With mode code 2'b10 (fixed-rate 9-bit), `os16_en` pulses once every 4 cycles when `dbl_rate`=0 and once every 2 cycles when `dbl_rate`=1.
- R3: With mode code 2'b01 or 2'b11 and `chain_sel`=0, `os16_en` pulses once for every two `tmr_ovf` pulses when `dbl_rate`=0 and once per `tmr_ovf` pulse when `dbl_rate`=1. Each enable appears in the cycle after the overflow pulse that completes the count.
- R4: With mode code 2'b01 or 2'b11 and `chain_sel`=1, `os16_en` pulses once every 156 cycles when `dbl_rate`=0 and once every 78 cycles when `dbl_rate`=1. This corresponds to a bit rate of 2^dbl·fclk/2496.
- R5: In mode codes 2'b00 and 2'b10, `tmr_ovf` and `chain_sel` have no effect on either output.
- R6: `shift_en` is asserted only while the mode code is 2'b00, and `os16_en` only while it is not.
- R7: A change of `sm_mode`, `dbl_rate` or `chain_sel` clears all dividers. No enable appears in the cycle after the change. For the clock-derived sources, the first enable comes exactly one full period after the clock edge that sees the change.
- R8: While `rst` is high both outputs are low. After `rst` falls in shift mode, the first `shift_en` appears 12 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sm_mode | input | 2 | Serial mode code: 00 shift, 01 8-bit variable, 10 9-bit fixed, 11 9-bit variable |
| dbl_rate | input | 1 | Rate-double: removes the final divide-by-two |
| chain_sel | input | 1 | Variable-rate source: 0 timer overflow, 1 internal divider chain |
| tmr_ovf | input | 1 | One-cycle overflow pulse from the external timer |
| shift_en | output | 1 | Bit enable for the synchronous shift mode |
| os16_en | output | 1 | Sixteen-times oversample enable for the asynchronous modes |

## Verification
A wrong divider count or a wrong limit shows at the ports as a changed number of enables within a window. For the slowest source that appears after at most two periods, which is 312 cycles. A counter that is not cleared on a configuration change shows up sooner, at the first enable after the change: the gap from the change to that enable is shorter or longer than one period. A wrong source selection shows within the first few enables, either as enables on the wrong output or as enables that do not follow the overflow pulses.

// File: rtl/serbaud_pkg.sv
package serbaud_pkg;

    typedef enum logic [1:0] {
        MODE_SHIFT = 2'b00,
        MODE_UART8 = 2'b01,
        MODE_FIX9  = 2'b10,
        MODE_VAR9  = 2'b11
    } sermode_e;

    typedef enum logic [1:0] {
        SRC_SYS   = 2'd0,
        SRC_TMR   = 2'd1,
        SRC_CHAIN = 2'd2
    } tick_src_e;

    typedef struct packed {
        sermode_e mode;
        logic     dbl;
        logic     intsrc;
    } rate_cfg_t;

    localparam rate_cfg_t CFG_RESET = '{mode: MODE_SHIFT, dbl: 1'b0, intsrc: 1'b0};

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic tick_src_e pick_src(input rate_cfg_t c);
        tick_src_e s;
        case (c.mode)
            MODE_SHIFT, MODE_FIX9: s = SRC_SYS;
            default:               s = c.intsrc ? SRC_CHAIN : SRC_TMR;
        endcase
        return s;
    endfunction

    // Final divide ratio: fixed in shift mode, halved by the rate-double bit elsewhere.
    function automatic int pick_limit(input rate_cfg_t c, input int shift_div,
                                      input int fix_div, input int async_div);
        int l;
        case (c.mode)
            MODE_SHIFT: l = shift_div;
            MODE_FIX9:  l = c.dbl ? fix_div / 2 : fix_div;
            default:    l = c.dbl ? async_div / 2 : async_div;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/baud_stage_div.sv
module baud_stage_div #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         hit
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt;

    assign hit = tick && (cnt == limit - ONE);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (tick)
            cnt <= hit ? '0 : cnt + ONE;
    end

    // R7
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && limit != '0) |-> (cnt < limit));

    // R7
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

endmodule

// File: rtl/serial_osc_chain.sv
module serial_osc_chain #(
    parameter int PRE_DIV   = 2,
    parameter int CHAIN_DIV = 39
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic chain_p
);
    localparam int PW = $clog2(PRE_DIV + 1);
    localparam int CW = $clog2(CHAIN_DIV + 1);

    logic pre_p;

    baud_stage_div #(.W(PW)) pre_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .tick  (1'b1),
        .limit (PW'(PRE_DIV)),
        .hit   (pre_p)
    );

    baud_stage_div #(.W(CW)) mid_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .tick  (pre_p),
        .limit (CW'(CHAIN_DIV)),
        .hit   (chain_p)
    );

    // R4
    chain_needs_pre_chk: assert property (@(posedge clk) disable iff (rst)
        chain_p |-> pre_p);

endmodule

// File: rtl/serial_rate_gen.sv
module serial_rate_gen
    import serbaud_pkg::*;
#(
    parameter int SHIFT_DIV = 12,
    parameter int FIX_DIV   = 4,
    parameter int PRE_DIV   = 2,
    parameter int CHAIN_DIV = 39,
    parameter int ASYNC_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sm_mode,
    input  logic       dbl_rate,
    input  logic       chain_sel,
    input  logic       tmr_ovf,
    output logic       shift_en,
    output logic       os16_en
);
    localparam int MAXL = imax(SHIFT_DIV, imax(FIX_DIV, ASYNC_DIV));
    localparam int LW   = $clog2(MAXL + 1);

    rate_cfg_t     cfg_now, cfg_q;
    logic          chg;
    logic          chain_p;
    logic          fin_tick;
    logic [LW-1:0] fin_limit;
    logic          fin_hit;
    tick_src_e     src;

    assign cfg_now = '{mode: sermode_e'(sm_mode), dbl: dbl_rate, intsrc: chain_sel};
    assign chg     = (cfg_now != cfg_q);

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= CFG_RESET;
        else     cfg_q <= cfg_now;
    end

    serial_osc_chain #(.PRE_DIV(PRE_DIV), .CHAIN_DIV(CHAIN_DIV)) chain_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (chg),
        .chain_p (chain_p)
    );

    always_comb begin
        src       = pick_src(cfg_now);
        fin_limit = LW'(pick_limit(cfg_now, SHIFT_DIV, FIX_DIV, ASYNC_DIV));
        case (src)
            SRC_TMR:   fin_tick = tmr_ovf;
            SRC_CHAIN: fin_tick = chain_p;
            default:   fin_tick = 1'b1;
        endcase
    end

    baud_stage_div #(.W(LW)) fin_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (chg),
        .tick  (fin_tick),
        .limit (fin_limit),
        .hit   (fin_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_en <= 1'b0;
            os16_en  <= 1'b0;
        end else begin
            shift_en <= fin_hit && !chg && (cfg_now.mode == MODE_SHIFT);
            os16_en  <= fin_hit && !chg && (cfg_now.mode != MODE_SHIFT);
        end
    end

    // R6
    shift_mode_only_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |-> ($past(sm_mode) == 2'b00));

    // R6
    os16_async_only_chk: assert property (@(posedge clk) disable iff (rst)
        os16_en |-> ($past(sm_mode) != 2'b00));

    // R7
    quiet_after_change_chk: assert property (@(posedge clk) disable iff (rst)
        chg |=> (!shift_en && !os16_en));

    // R3
    timer_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (os16_en && $past(sm_mode[0]) && !$past(chain_sel)) |-> $past(tmr_ovf));

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!shift_en && !os16_en));

endmodule

// File: tb/serial_rate_gen_tb_top.sv
module serial_rate_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sm_mode = 2'b00;
    logic       dbl_rate = 1'b0;
    logic       chain_sel = 1'b0;
    logic       tmr_ovf = 1'b0;
    logic       shift_en, os16_en;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    serial_rate_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .sm_mode   (sm_mode),
        .dbl_rate  (dbl_rate),
        .chain_sel (chain_sel),
        .tmr_ovf   (tmr_ovf),
        .shift_en  (shift_en),
        .os16_en   (os16_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Period in cycles for clock-derived sources; 0 means the timer source.
    function automatic int exp_period(input logic [1:0] m, input logic s, input logic b);
        if (m == 2'b00) return 12;
        if (m == 2'b10) return s ? 2 : 4;
        if (b)          return s ? 78 : 156;
        return 0;
    endfunction

    task automatic run_case(input logic [1:0] m, input logic s, input logic b,
                            input int t, input int n, input string tag);
        int n_sh = 0, n_os = 0, n_ovf = 0, first = 0, per, exp_sh, exp_os;
        @(negedge clk);
        sm_mode = m ^ 2'b01; dbl_rate = s; chain_sel = b; tmr_ovf = 1'b0;
        repeat (3) @(negedge clk);
        sm_mode = m;
        @(posedge clk);
        for (int i = 1; i <= n; i++) begin
            @(posedge clk);
            #1;
            tmr_ovf = 1'b0;
            if (shift_en) n_sh++;
            if (os16_en)  n_os++;
            if ((shift_en || os16_en) && first == 0) first = i;
            if (t > 0 && (i % t) == 0 && i <= n - 3) begin
                tmr_ovf = 1'b1;
                n_ovf++;
            end
        end
        #1 tmr_ovf = 1'b0;
        per = exp_period(m, s, b);
        exp_sh = (m == 2'b00) ? n / 12 : 0;
        if (m == 2'b00)  exp_os = 0;
        else if (per > 0) exp_os = n / per;
        else             exp_os = s ? n_ovf : n_ovf / 2;
        chk(n_sh == exp_sh, {tag, " R1/R6 shift count"}, n_sh, exp_sh);
        if (m == 2'b10)      chk(n_os == exp_os, {tag, " R2 R5 os16 count"}, n_os, exp_os);
        else if (m == 2'b00) chk(n_os == exp_os, {tag, " R1 R5 os16 count"}, n_os, exp_os);
        else if (b)          chk(n_os == exp_os, {tag, " R4 os16 count"}, n_os, exp_os);
        else                 chk(n_os == exp_os, {tag, " R3 os16 count"}, n_os, exp_os);
        if (per > 0)
            chk(first == per, {tag, " R7 first enable after change"}, first, per);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int first;
        void'($urandom(32'd4242));
        // R8: outputs low during reset
        repeat (4) begin
            @(posedge clk); #1;
            chk(!shift_en && !os16_en, "R8 outputs low in reset", {shift_en, os16_en}, 0);
        end
        @(negedge clk);
        rst = 1'b0;
        first = 0;
        for (int i = 1; i <= 30; i++) begin
            @(posedge clk); #1;
            if (shift_en && first == 0) first = i;
        end
        chk(first == 12, "R8 first shift enable after reset", first, 12);

        // Directed: every mode / rate-double / source combination
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 2; s++)
                for (int b = 0; b < 2; b++)
                    run_case(2'(m), 1'(s), 1'(b), 5, 700, "directed");

        // Corner: overflow every cycle with rate-double, and sparse overflow
        run_case(2'b01, 1'b1, 1'b0, 1, 200, "ovf_each_cycle");
        run_case(2'b11, 1'b0, 1'b0, 37, 900, "ovf_sparse");
        // R5: overflow pulses in fixed-rate mode with internal source selected
        run_case(2'b10, 1'b0, 1'b1, 2, 300, "fixed_ignores_ovf");

        // R8: reset in the middle of a fast mode
        @(negedge clk);
        sm_mode = 2'b10; dbl_rate = 1'b1;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        repeat (3) begin
            @(posedge clk); #1;
            chk(!shift_en && !os16_en, "R8 outputs low in mid-run reset", {shift_en, os16_en}, 0);
        end
        @(negedge clk);
        rst = 1'b0;

        // Random configurations
        for (int k = 0; k < 20; k++) begin
            logic [1:0] m = 2'($urandom_range(0, 3));
            logic s = 1'($urandom_range(0, 1));
            logic b = 1'($urandom_range(0, 1));
            int t = $urandom_range(1, 9);
            run_case(m, s, b, t, 400 + $urandom_range(0, 300), "random");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule